// File: doc/BRIEF.md
# Event Timestamp Capture Slice

This block watches one of 64 external event lines and, each time the chosen line makes the configured transition, stores a snapshot of two free-running timebases: a time-of-day value (seconds and nanoseconds words) and a 64-bit global counter. Each snapshot also carries a small event-type code. Snapshots are held in a four-entry queue that software drains through a word-addressed register port. An interrupt line stays high while the queue holds entries, as long as the interrupt is enabled.

The selected line passes through a two-flop synchronizer before edge detection, so event lines may be asynchronous to the slice clock. Each timebase has its own capture enable. A snapshot is stored only when at least one of the two enables is set and the queue has room. A clear register lets software wipe the time-of-day storage, the counter storage and the type/queue state separately. The intended sequence is to drop both enables, clear, and then enable again.

The register port uses a 3-bit word address. Word 0 is the configuration, 1 is the status, 2 holds the nanoseconds word (reading it pops the entry), 3 the seconds word, 4 and 5 the counter's low and high words, 6 the event type and 7 the clear control. Read data appears on `rdata_o` one clock after the read strobe.

Top module: `evt_capture_slice`

## Requirements
- R1: After reset, the configuration and status read as zero, `irq_o` is low, and `rdata_o` is zero.
- R2: Configuration bits 9:4 select which of the 64 event lines is watched. Transitions on all other lines never create a capture.
- R3: Configuration bit 0 picks the active transition: 1 means a low-to-high change, 0 means a high-to-low change. The opposite transition creates no capture.
- R4: Configuration bit 16 enables storing the global counter and bit 17 enables storing the time-of-day. With neither bit set, no capture happens. A timebase whose bit is clear is stored as zero.
- R5: When a level change on the selected line is sampled at clock edge k, the capture is pushed at edge k+2 and records the timebase values present at that edge.
- R6: Status bits 5:0 give the number of stored entries, from 0 to 4. A capture that arrives while 4 entries are stored is dropped.
- R7: A read of word 2 while entries are stored removes the oldest entry. A read of word 2 on an empty queue leaves the count at zero. Reads of the other words never remove an entry.
- R8: Entries are returned oldest first.
- R9: `irq_o` is high exactly when configuration bit 31 is set and the entry count is nonzero.
- R10: A write to word 7 acts per bit. Bit 0 zeroes every stored time-of-day field. Bit 1 zeroes every stored counter field. Bit 2 zeroes every stored type field and empties the queue. A capture that coincides with a clear write is dropped.
- R11: The event-type word holds the selected line number in bits 5:0 and the active-transition setting in bit 6, captured at the time of the event. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slice clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 64 | External event lines, may be asynchronous |
| tod_sec_i | input | 32 | Time-of-day seconds |
| tod_ns_i | input | 32 | Time-of-day nanoseconds |
| gctr_i | input | 64 | Global counter value |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid one clock after `re_i` |
| irq_o | output | 1 | Capture-pending interrupt |

## Verification
Three different delays govern the results, and each check is timed to match.

- **Captures:** an event level driven between edges is seen by the first synchronizer flop at the next edge and is stored two edges later. The bench therefore waits four clock periods after each event before reading the status. The latency test changes the timebase inputs exactly one edge before the expected push edge, and then again right after it, to show which edge is sampled.
- **Register reads:** read data is registered, so the bench raises the strobe for one cycle and samples `rdata_o` at the falling edge after the capturing edge.
- **Writes and interrupt:** a write, a pop or a clear takes effect at the edge that samples it. `irq_o` follows the count with no added delay, so it is checked at the same falling edge as the status.

// File: rtl/evt_slice_pkg.sv
package evt_slice_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int SEL_W   = 6;
    localparam int EVT_N   = 1 << SEL_W;
    localparam int STAT_W  = 6;

    localparam int CFG_POL_BIT = 0;
    localparam int CFG_SEL_LSB = 4;
    localparam int CFG_GEN_BIT = 16;
    localparam int CFG_TEN_BIT = 17;
    localparam int CFG_IE_BIT  = 31;

    localparam int CLR_TOD = 0;
    localparam int CLR_GCT = 1;
    localparam int CLR_TYP = 2;
    localparam int CLR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG    = 3'd0,
        RA_STAT   = 3'd1,
        RA_TOD_NS = 3'd2,
        RA_TOD_S  = 3'd3,
        RA_GC_LO  = 3'd4,
        RA_GC_HI  = 3'd5,
        RA_ETYPE  = 3'd6,
        RA_CLEAR  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [WORD_W-1:0] sec;
        logic [WORD_W-1:0] ns;
    } tod_t;

    typedef struct packed {
        logic             rise;
        logic [SEL_W-1:0] sel;
    } etype_t;

    typedef struct packed {
        tod_t                tod;
        logic [2*WORD_W-1:0] gctr;
        etype_t              typ;
    } cap_t;

    typedef struct packed {
        logic             ie;
        logic             tod_en;
        logic             gct_en;
        logic [SEL_W-1:0] sel;
        logic             rise;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.ie     = w[CFG_IE_BIT];
        c.tod_en = w[CFG_TEN_BIT];
        c.gct_en = w[CFG_GEN_BIT];
        c.sel    = w[CFG_SEL_LSB +: SEL_W];
        c.rise   = w[CFG_POL_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CFG_IE_BIT]              = c.ie;
        w[CFG_TEN_BIT]             = c.tod_en;
        w[CFG_GEN_BIT]             = c.gct_en;
        w[CFG_SEL_LSB +: SEL_W]    = c.sel;
        w[CFG_POL_BIT]             = c.rise;
        return w;
    endfunction

endpackage

// File: rtl/evt_sel_edge.sv
module evt_sel_edge
    import evt_slice_pkg::*;
#(
    parameter int N_EVT  = EVT_N,
    parameter int STAGES = 2,
    localparam int SW    = $clog2(N_EVT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [SW-1:0]    sel_i,
    input  logic             rise_i,
    output logic             edge_o
);

    logic              picked;
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    assign picked = evt_i[sel_i];

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= picked;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[s] <= 1'b0;
            else     sync_q[s] <= sync_q[s-1];
        end
    end

    assign lvl = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    always_comb begin
        if (rise_i) edge_o = lvl & ~prev_q;
        else        edge_o = ~lvl & prev_q;
    end

endmodule

// File: rtl/evt_cap_fifo.sv
module evt_cap_fifo
    import evt_slice_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = STAT_W,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  cap_t             entry_i,
    input  logic             pop_i,
    input  logic [CLR_W-1:0] clr_i,
    output cap_t             head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);

    tod_t                tod_mem [DEPTH];
    logic [2*WORD_W-1:0] gct_mem [DEPTH];
    etype_t              typ_mem [DEPTH];

    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clr_any, do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign clr_any = |clr_i;
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push_i & ~full_o & ~clr_any;
    assign do_pop  = pop_i & (cnt_q != '0) & ~clr_any;

    always_ff @(posedge clk) begin
        if (rst || clr_i[CLR_TYP]) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= ptr_next(wp_q);
            if (do_pop)  rp_q <= ptr_next(rp_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                tod_mem[i] <= '0;
                gct_mem[i] <= '0;
                typ_mem[i] <= '0;
            end else begin
                if (do_push && wp_q == PTR_W'(i)) begin
                    tod_mem[i] <= entry_i.tod;
                    gct_mem[i] <= entry_i.gctr;
                    typ_mem[i] <= entry_i.typ;
                end
                if (clr_i[CLR_TOD]) tod_mem[i] <= '0;
                if (clr_i[CLR_GCT]) gct_mem[i] <= '0;
                if (clr_i[CLR_TYP]) typ_mem[i] <= '0;
            end
        end
    end

    always_comb begin
        head_o.tod  = tod_mem[rp_q];
        head_o.gctr = gct_mem[rp_q];
        head_o.typ  = typ_mem[rp_q];
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/evt_capture_slice.sv
module evt_capture_slice
    import evt_slice_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [EVT_N-1:0]    evt_i,
    input  logic [WORD_W-1:0]   tod_sec_i,
    input  logic [WORD_W-1:0]   tod_ns_i,
    input  logic [2*WORD_W-1:0] gctr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    input  logic                we_i,
    input  logic                re_i,
    output logic [WORD_W-1:0]   rdata_o,
    output logic                irq_o
);

    cfg_t               cfg_q;
    reg_addr_e          ra;
    logic               edge_hit, push_req, pop_req;
    logic [CLR_W-1:0]   clr_req;
    cap_t               new_cap, head;
    logic [STAT_W-1:0]  fifo_cnt;
    logic               fifo_full;
    logic               cfg_gen, cfg_ten, cfg_ie;
    logic [WORD_W-1:0]  rd_mux;

    assign ra      = reg_addr_e'(addr_i);
    assign cfg_gen = cfg_q.gct_en;
    assign cfg_ten = cfg_q.tod_en;
    assign cfg_ie  = cfg_q.ie;

    always_ff @(posedge clk) begin
        if (rst)                       cfg_q <= '0;
        else if (we_i && ra == RA_CFG) cfg_q <= cfg_unpack(wdata_i);
    end

    evt_sel_edge #(
        .N_EVT (EVT_N),
        .STAGES(SYNC_STAGES)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .sel_i (cfg_q.sel),
        .rise_i(cfg_q.rise),
        .edge_o(edge_hit)
    );

    assign push_req = edge_hit & (cfg_gen | cfg_ten);
    assign pop_req  = re_i && (ra == RA_TOD_NS);
    assign clr_req  = (we_i && ra == RA_CLEAR) ? wdata_i[CLR_W-1:0] : '0;

    always_comb begin
        new_cap.tod.sec = cfg_ten ? tod_sec_i : '0;
        new_cap.tod.ns  = cfg_ten ? tod_ns_i  : '0;
        new_cap.gctr    = cfg_gen ? gctr_i    : '0;
        new_cap.typ     = '{rise: cfg_q.rise, sel: cfg_q.sel};
    end

    evt_cap_fifo #(
        .DEPTH(DEPTH),
        .CNT_W(STAT_W)
    ) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_i (push_req),
        .entry_i(new_cap),
        .pop_i  (pop_req),
        .clr_i  (clr_req),
        .head_o (head),
        .count_o(fifo_cnt),
        .full_o (fifo_full)
    );

    always_comb begin
        rd_mux = '0;
        case (ra)
            RA_CFG:    rd_mux = cfg_pack(cfg_q);
            RA_STAT:   rd_mux = WORD_W'(fifo_cnt);
            RA_TOD_NS: rd_mux = head.tod.ns;
            RA_TOD_S:  rd_mux = head.tod.sec;
            RA_GC_LO:  rd_mux = head.gctr[WORD_W-1:0];
            RA_GC_HI:  rd_mux = head.gctr[2*WORD_W-1:WORD_W];
            RA_ETYPE:  rd_mux = WORD_W'(head.typ);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_o <= '0;
        else if (re_i) rdata_o <= rd_mux;
    end

    assign irq_o = cfg_ie & (fifo_cnt != '0);

endmodule

// File: rtl/evt_slice_chk.sv
module evt_slice_chk
    import evt_slice_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [STAT_W-1:0] cnt,
    input logic              full,
    input logic              push_req,
    input logic              pop_req,
    input logic [CLR_W-1:0]  clr_req,
    input logic              edge_hit,
    input logic              gen,
    input logic              ten,
    input logic              ie,
    input logic              irq
);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= STAT_W'(DEPTH));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !pop_req && clr_req == '0) |=> cnt == STAT_W'(DEPTH));

    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_hit && !gen && !ten && !pop_req && clr_req == '0) |=> $stable(cnt));

    p_irq_hi_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie && cnt != '0));

    p_irq_req_r9: assert property (@(posedge clk) disable iff (rst)
        (ie && cnt != '0) |-> irq);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr_req[CLR_TYP] |=> cnt == '0);

    p_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_req && cnt != '0 && !push_req && clr_req == '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

bind evt_capture_slice evt_slice_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt     (fifo_cnt),
    .full    (fifo_full),
    .push_req(push_req),
    .pop_req (pop_req),
    .clr_req (clr_req),
    .edge_hit(edge_hit),
    .gen     (cfg_gen),
    .ten     (cfg_ten),
    .ie      (cfg_ie),
    .irq     (irq_o)
);

// File: tb/tb_evt_capture_slice.sv
module tb_evt_capture_slice;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] evt = '0;
    logic [31:0] tsec = '0, tns = '0;
    logic [63:0] gc = '0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0, fails = 0;
    bit done = 0;

    localparam logic [31:0] EN_BOTH = 32'h0003_0000;
    localparam logic [31:0] EN_GC   = 32'h0001_0000;
    localparam logic [31:0] EN_TOD  = 32'h0002_0000;
    localparam logic [31:0] IE      = 32'h8000_0000;

    always #2 clk = ~clk;

    evt_capture_slice dut (
        .clk(clk), .rst(rst), .evt_i(evt), .tod_sec_i(tsec), .tod_ns_i(tns),
        .gctr_i(gc), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; re = 1'b1;
        @(negedge clk); re = 1'b0; v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int s);
        @(negedge clk); evt[s] = 1'b1;
        idle(4);
        evt[s] = 1'b0;
        idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 irq", irq, 0);
        rd(3'd0, v); chk("R1 cfg", v, 0);
        rd(3'd1, v); chk("R1 status", v, 0);

        // R2 R3 R11 sweep over every select value and both polarities
        for (int s = 0; s < 64; s++) begin
            for (int p = 0; p < 2; p++) begin
                logic [31:0] cfgw;
                cfgw = EN_BOTH | (32'(s) << 4) | 32'(p) | (p == 1 ? IE : 32'h0);
                wr(3'd0, cfgw);
                idle(4);
                tsec = 32'h1000 + 32'(s);
                tns  = 32'h2000 + 32'(s * 2 + p);
                gc   = {32'hA500_0000 | 32'(s), 32'h5A00_0000 | 32'(s * 2 + p)};
                @(negedge clk); evt = ~(64'd1 << s);
                idle(4);
                @(negedge clk); evt = '0;
                idle(4);
                rd(3'd1, v); chk("R2 others ignored", v, 0);
                @(negedge clk); evt[s] = 1'b1;
                idle(4);
                rd(3'd1, v); chk("R3 after low-to-high", v, (p == 1) ? 1 : 0);
                @(negedge clk); evt[s] = 1'b0;
                idle(4);
                rd(3'd1, v); chk("R3 after high-to-low", v, 1);
                chk("R9 irq follows enable", irq, (p == 1) ? 1 : 0);
                rd(3'd3, v); chk("R2 tod sec", v, 32'h1000 + 32'(s));
                rd(3'd5, v); chk("R2 gctr hi", v, 32'hA500_0000 | 32'(s));
                rd(3'd4, v); chk("R2 gctr lo", v, 32'h5A00_0000 | 32'(s * 2 + p));
                rd(3'd6, v); chk("R11 event type", v, 32'(p * 64 + s));
                rd(3'd2, v); chk("R7 tod ns pop", v, 32'h2000 + 32'(s * 2 + p));
                rd(3'd1, v); chk("R7 count after pop", v, 0);
            end
        end

        // R5 capture latency and sampled values
        wr(3'd0, EN_BOTH | (32'd9 << 4) | 32'd1);
        idle(4);
        tns = 32'h111; gc = 64'h111;
        @(negedge clk); evt[9] = 1'b1;
        @(negedge clk);
        @(negedge clk); tns = 32'hAAA; gc = 64'hAAA;
        rd(3'd1, v);
        chk("R5 pushed two edges after sampling", v, 1);
        tns = 32'hBBB; gc = 64'hBBB;
        evt[9] = 1'b0;
        idle(4);
        rd(3'd4, v); chk("R5 counter sampled at push edge", v, 32'hAAA);
        rd(3'd2, v); chk("R5 tod sampled at push edge", v, 32'hAAA);

        // R4 enables
        wr(3'd0, EN_TOD | (32'd9 << 4) | 32'd1);
        tsec = 32'h77; tns = 32'h88; gc = 64'h1234_5678_9ABC_DEF0;
        pulse(9);
        rd(3'd4, v); chk("R4 counter disabled lo zero", v, 0);
        rd(3'd5, v); chk("R4 counter disabled hi zero", v, 0);
        rd(3'd3, v); chk("R4 tod enabled sec", v, 32'h77);
        rd(3'd2, v); chk("R4 tod enabled ns", v, 32'h88);
        wr(3'd0, EN_GC | (32'd9 << 4) | 32'd1);
        pulse(9);
        rd(3'd3, v); chk("R4 tod disabled zero", v, 0);
        rd(3'd5, v); chk("R4 counter enabled hi", v, 32'h1234_5678);
        rd(3'd2, v);
        wr(3'd0, (32'd9 << 4) | 32'd1);
        pulse(9);
        rd(3'd1, v); chk("R4 no enable no capture", v, 0);

        // R6 R7 R8 full queue and ordering
        wr(3'd0, EN_BOTH | (32'd5 << 4) | 32'd1);
        for (int i = 0; i < 5; i++) begin
            tns = 32'd100 + 32'(i);
            pulse(5);
        end
        rd(3'd1, v); chk("R6 count saturates at 4", v, 4);
        rd(3'd3, v);
        rd(3'd6, v);
        rd(3'd1, v); chk("R7 other reads keep entries", v, 4);
        chk("R9 irq off while disabled", irq, 0);
        for (int i = 0; i < 4; i++) begin
            rd(3'd2, v); chk("R8 oldest first", v, 32'd100 + 32'(i));
        end
        rd(3'd1, v); chk("R6 drained", v, 0);
        rd(3'd2, v);
        rd(3'd1, v); chk("R7 pop on empty", v, 0);

        // R10 group clears
        wr(3'd0, IE | EN_BOTH | (32'd5 << 4) | 32'd1);
        tsec = 32'h55; gc = 64'h66;
        pulse(5);
        pulse(5);
        rd(3'd1, v); chk("R6 two stored", v, 2);
        wr(3'd7, 32'h1);
        rd(3'd1, v); chk("R10 tod clear keeps count", v, 2);
        rd(3'd3, v); chk("R10 tod cleared", v, 0);
        rd(3'd4, v); chk("R10 counter kept", v, 32'h66);
        wr(3'd7, 32'h2);
        rd(3'd4, v); chk("R10 counter cleared", v, 0);
        rd(3'd6, v); chk("R10 type kept", v, 32'h45);
        chk("R9 irq with entries", irq, 1);
        wr(3'd7, 32'h4);
        rd(3'd1, v); chk("R10 queue emptied", v, 0);
        rd(3'd6, v); chk("R10 type cleared", v, 0);
        chk("R9 irq low when empty", irq, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule